// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block is the privileged control register set and entry/return sequencer that sits beside the pipeline of a simple 32-bit processor. It keeps four numbered registers: the faulting data address, the processor status word, the cause of the last exception and the saved program counter. It watches up to eight level-sensitive interrupt request lines and three internal fault pulses: arithmetic overflow, load address error and store address error. On every cycle in which the processor reports that it is about to fetch a new instruction, it decides whether to redirect fetch to the kernel handler or back to the saved program counter.

The processor talks to the block through one register port. The port has a number, a write strobe, write data and a combinational read-back. A fetch redirect leaves the block as a valid flag and a target address in the same cycle as the instruction boundary. The register effects of an entry or a return appear from the next clock edge on. The processor raises a return strobe when it executes its return-from-exception instruction, and the block then resumes the interrupted code with its earlier status.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset all four registers read zero, and no redirect is raised until an event arrives.
- R2: Register numbers are fixed: 8 is the faulting address, 12 is status, 13 is cause and 14 is the saved PC. Any other number reads zero.
- R3: Only status bits 15:8 (interrupt mask, one bit per line), 4 (user mode), 1 (exception level) and 0 (interrupt enable) can be written. All other status bits always read zero.
- R4: Cause bits 15:8 follow the request lines live, with line n at bit 8+n. Cause holds the branch-delay flag in bit 31 and the 5-bit code in bits 6:2. Software writes to cause (13) and to the faulting address (8) have no effect.
- R5: A redirect is raised only in a cycle with the boundary input high. Faults and requests in other cycles are dropped and change no register.
- R6: On entry the block raises the redirect with target 0x80000180 in the same cycle. From the next edge on, the saved PC holds the boundary PC, the branch-delay flag copies the delay input, exception level is 1, user mode is 0 and the code is loaded.
- R7: Codes are 4 for a load address error, 5 for a store address error and 12 for overflow. An interrupt gets 16 plus the index of the highest-numbered line that is allowed. Faults rank load error, then store error, then overflow, and any fault beats an interrupt.
- R8: A request line is taken only when its mask bit is 1, interrupt enable is 1 and exception level is 0.
- R9: The faulting address input is captured only on an address error entry. Overflow and interrupt entries leave it unchanged.
- R10: A return strobe at a boundary that takes no exception redirects to the saved PC. From the next edge on, status equals its value from just before the matching entry.
- R11: In a cycle that performs an entry or a return, a software register write is dropped.
- R12: An entry taken while exception level is already 1 still vectors and loads the code. It leaves the saved PC, the branch-delay flag and the saved status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Processor is about to fetch the next instruction |
| pc_i | input | 32 | Address of the instruction that is completing |
| in_delay_i | input | 1 | That instruction sits in a branch delay slot |
| ovf_i | input | 1 | Arithmetic overflow fault |
| aerr_ld_i | input | 1 | Load address error fault |
| aerr_st_i | input | 1 | Store address error fault |
| fault_addr_i | input | 32 | Data address of the faulting access |
| irq_i | input | NIRQ | Interrupt request lines, level sensitive |
| eret_i | input | 1 | Return-from-exception instruction executing |
| cp_we_i | input | 1 | Register port write strobe |
| cp_addr_i | input | 5 | Register number for read and write |
| cp_wdata_i | input | 32 | Register port write data |
| cp_rdata_o | output | 32 | Register port read data (combinational) |
| redirect_o | output | 1 | Fetch must be redirected this cycle |
| redirect_pc_o | output | 32 | Target of the redirect |

## Verification
The redirect flag and target are combinational, so they are due in the boundary cycle itself. The bench samples them 2 ns after the falling edge, before the rising edge that retires the event. Register effects of an entry, a return or a software write land on that rising edge, and the bench reads them back through the read port after the following falling edge. The pending field of cause follows the request lines with no register in the path, so it is compared in the same low phase in which the lines were changed.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
   localparam int IRQ_MAX = 8;
   localparam int IDX_W   = $clog2(IRQ_MAX);
   localparam int RN_W    = 5;

   localparam logic [RN_W-1:0] RN_BADVA  = 5'd8;
   localparam logic [RN_W-1:0] RN_STATUS = 5'd12;
   localparam logic [RN_W-1:0] RN_CAUSE  = 5'd13;
   localparam logic [RN_W-1:0] RN_EPC    = 5'd14;

   localparam int ST_IE  = 0;
   localparam int ST_EXL = 1;
   localparam int ST_UM  = 4;
   localparam int ST_MSK = 8;

   localparam logic [4:0] EC_ADEL     = 5'd4;
   localparam logic [4:0] EC_ADES     = 5'd5;
   localparam logic [4:0] EC_OVF      = 5'd12;
   localparam logic [4:0] EC_IRQ_BASE = 5'd16;

   typedef struct packed {
      logic       take;
      logic       ret;
      logic       aerr;
      logic [4:0] code;
   } exc_dec_t;
endpackage

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter
   import exc_pkg::*;
#(
   parameter int NIRQ          = 8,
   parameter bit IRQ_HIGH_WINS = 1'b1
) (
   input  logic            boundary,
   input  logic            ovf,
   input  logic            aerr_ld,
   input  logic            aerr_st,
   input  logic            eret,
   input  logic [NIRQ-1:0] irq,
   input  logic [NIRQ-1:0] mask,
   input  logic            ie,
   input  logic            exl,
   output exc_dec_t        dec
);
   logic [NIRQ-1:0]  allowed;
   logic [IDX_W-1:0] irq_idx;
   logic             irq_any;
   logic             fault;

   assign allowed = irq & mask & {NIRQ{ie & ~exl}};
   assign fault   = ovf | aerr_ld | aerr_st;

   generate
      if (IRQ_HIGH_WINS) begin : g_high_first
         always_comb begin
            irq_idx = '0;
            irq_any = 1'b0;
            for (int i = 0; i < NIRQ; i++) begin
               if (allowed[i]) begin
                  irq_idx = IDX_W'(i);
                  irq_any = 1'b1;
               end
            end
         end
      end else begin : g_low_first
         always_comb begin
            irq_idx = '0;
            irq_any = 1'b0;
            for (int i = NIRQ - 1; i >= 0; i--) begin
               if (allowed[i]) begin
                  irq_idx = IDX_W'(i);
                  irq_any = 1'b1;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      dec.take = boundary & (fault | irq_any);
      dec.ret  = boundary & eret & ~dec.take;
      dec.aerr = aerr_ld | aerr_st;
      if (aerr_ld)      dec.code = EC_ADEL;
      else if (aerr_st) dec.code = EC_ADES;
      else if (ovf)     dec.code = EC_OVF;
      else              dec.code = EC_IRQ_BASE + 5'(irq_idx);
   end
endmodule

// File: rtl/exc_csr_file.sv
`timescale 1ns/1ps
module exc_csr_file
   import exc_pkg::*;
#(
   parameter int NIRQ = 8,
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  exc_dec_t        dec,
   input  logic [XLEN-1:0] pc,
   input  logic            in_delay,
   input  logic [XLEN-1:0] fault_addr,
   input  logic [NIRQ-1:0] irq,
   input  logic            we,
   input  logic [RN_W-1:0] addr,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] rdata,
   output logic [XLEN-1:0] status,
   output logic [XLEN-1:0] shadow,
   output logic [XLEN-1:0] epc
);
   localparam logic [XLEN-1:0] MASK_FIELD = XLEN'(((1 << NIRQ) - 1) << ST_MSK);
   localparam logic [XLEN-1:0] MODE_BITS  =
      XLEN'((1 << ST_UM) | (1 << ST_EXL) | (1 << ST_IE));
   localparam logic [XLEN-1:0] ST_WMASK   = MASK_FIELD | MODE_BITS;

   logic [XLEN-1:0] status_q, shadow_q, epc_q, badva_q;
   logic [4:0]      code_q;
   logic            bd_q;
   logic [7:0]      pend;
   logic [XLEN-1:0] cause;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         shadow_q <= '0;
         epc_q    <= '0;
         badva_q  <= '0;
         code_q   <= '0;
         bd_q     <= 1'b0;
      end else if (dec.take) begin
         code_q <= dec.code;
         if (!status_q[ST_EXL]) begin
            epc_q    <= pc;
            bd_q     <= in_delay;
            shadow_q <= status_q;
         end
         status_q[ST_UM]  <= 1'b0;
         status_q[ST_EXL] <= 1'b1;
         if (dec.aerr) badva_q <= fault_addr;
      end else if (dec.ret) begin
         status_q <= shadow_q;
      end else if (we) begin
         case (addr)
            RN_STATUS: status_q <= wdata & ST_WMASK;
            RN_EPC:    epc_q    <= wdata;
            default:   ;
         endcase
      end
   end

   always_comb begin
      pend           = '0;
      pend[NIRQ-1:0] = irq;
      cause          = {bd_q, 15'b0, pend, 1'b0, code_q, 2'b00};
      case (addr)
         RN_BADVA:  rdata = badva_q;
         RN_STATUS: rdata = status_q;
         RN_CAUSE:  rdata = cause;
         RN_EPC:    rdata = epc_q;
         default:   rdata = '0;
      endcase
   end

   assign status = status_q;
   assign shadow = shadow_q;
   assign epc    = epc_q;
endmodule

// File: rtl/exc_ctrl_unit.sv
`timescale 1ns/1ps
module exc_ctrl_unit
   import exc_pkg::*;
#(
   parameter int          NIRQ          = 8,
   parameter int          XLEN          = 32,
   parameter logic [31:0] VECTOR        = 32'h8000_0180,
   parameter bit          IRQ_HIGH_WINS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            boundary_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic            in_delay_i,
   input  logic            ovf_i,
   input  logic            aerr_ld_i,
   input  logic            aerr_st_i,
   input  logic [XLEN-1:0] fault_addr_i,
   input  logic [NIRQ-1:0] irq_i,
   input  logic            eret_i,
   input  logic            cp_we_i,
   input  logic [RN_W-1:0] cp_addr_i,
   input  logic [XLEN-1:0] cp_wdata_i,
   output logic [XLEN-1:0] cp_rdata_o,
   output logic            redirect_o,
   output logic [XLEN-1:0] redirect_pc_o
);
   generate
      if (NIRQ < 1 || NIRQ > IRQ_MAX) begin : g_bad_nirq
         $error("exc_ctrl_unit: NIRQ must lie in 1..8");
      end
      if (XLEN != 32) begin : g_bad_xlen
         $error("exc_ctrl_unit: register layout needs XLEN of 32");
      end
      if (VECTOR[1:0] != 2'b00) begin : g_bad_vec
         $error("exc_ctrl_unit: VECTOR must be word aligned");
      end
   endgenerate

   exc_dec_t        dec;
   logic [XLEN-1:0] status_w, shadow_w, epc_w;

   exc_arbiter #(.NIRQ(NIRQ), .IRQ_HIGH_WINS(IRQ_HIGH_WINS)) u_arb (
      .boundary (boundary_i),
      .ovf      (ovf_i),
      .aerr_ld  (aerr_ld_i),
      .aerr_st  (aerr_st_i),
      .eret     (eret_i),
      .irq      (irq_i),
      .mask     (status_w[ST_MSK +: NIRQ]),
      .ie       (status_w[ST_IE]),
      .exl      (status_w[ST_EXL]),
      .dec      (dec)
   );

   exc_csr_file #(.NIRQ(NIRQ), .XLEN(XLEN)) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .dec        (dec),
      .pc         (pc_i),
      .in_delay   (in_delay_i),
      .fault_addr (fault_addr_i),
      .irq        (irq_i),
      .we         (cp_we_i),
      .addr       (cp_addr_i),
      .wdata      (cp_wdata_i),
      .rdata      (cp_rdata_o),
      .status     (status_w),
      .shadow     (shadow_w),
      .epc        (epc_w)
   );

   assign redirect_o    = dec.take | dec.ret;
   assign redirect_pc_o = dec.take ? XLEN'(VECTOR) : epc_w;
endmodule

// File: rtl/exc_ctrl_unit_chk.sv
`timescale 1ns/1ps
module exc_ctrl_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        boundary_i,
   input logic        ovf_i,
   input logic        aerr_ld_i,
   input logic        aerr_st_i,
   input logic        eret_i,
   input logic [31:0] pc_i,
   input logic        redirect_o,
   input logic [31:0] redirect_pc_o,
   input logic [31:0] vec,
   input logic [31:0] status,
   input logic [31:0] shadow,
   input logic [31:0] epc
);
   logic fault;
   assign fault = ovf_i | aerr_ld_i | aerr_st_i;

   a_r5_off_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary_i |-> !redirect_o);

   a_r6_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && fault) |-> (redirect_o && redirect_pc_o == vec));

   a_r6_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && fault) |=> (status[1] && !status[4]));

   a_r6_epc_saved: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && fault && !status[1]) |=> (epc == $past(pc_i)));

   a_r8_exl_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && !fault && !eret_i && status[1]) |-> !redirect_o);

   a_r10_return_target: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && eret_i && !fault && status[1]) |-> (redirect_o && redirect_pc_o == epc));

   a_r10_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && eret_i && !fault && status[1]) |=> (status == $past(shadow)));

   a_r12_epc_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && fault && status[1]) |=> $stable(epc));
endmodule

bind exc_ctrl_unit exc_ctrl_unit_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .boundary_i    (boundary_i),
   .ovf_i         (ovf_i),
   .aerr_ld_i     (aerr_ld_i),
   .aerr_st_i     (aerr_st_i),
   .eret_i        (eret_i),
   .pc_i          (pc_i),
   .redirect_o    (redirect_o),
   .redirect_pc_o (redirect_pc_o),
   .vec           (VECTOR),
   .status        (status_w),
   .shadow        (shadow_w),
   .epc           (epc_w)
);

// File: tb/exc_ctrl_unit_test.sv
`timescale 1ns/1ps
module exc_ctrl_unit_test;
   localparam logic [31:0] VEC = 32'h8000_0180;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bnd = 0, dly = 0, ovf = 0, ald = 0, ast = 0, eret = 0, we = 0;
   logic [31:0] pc = 0, fa = 0, wdata = 0;
   logic [7:0]  irq = 0;
   logic [4:0]  addr = 0;
   logic [31:0] rdata, rpc;
   logic        red;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   logic [31:0] m_status = 0, m_shadow = 0, m_epc = 0, m_badva = 0;
   logic [4:0]  m_code = 0;
   logic        m_bd = 0;

   always #10 clk = ~clk;

   exc_ctrl_unit uut (
      .clk(clk), .rst_n(rst_n), .boundary_i(bnd), .pc_i(pc), .in_delay_i(dly),
      .ovf_i(ovf), .aerr_ld_i(ald), .aerr_st_i(ast), .fault_addr_i(fa),
      .irq_i(irq), .eret_i(eret), .cp_we_i(we), .cp_addr_i(addr),
      .cp_wdata_i(wdata), .cp_rdata_o(rdata), .redirect_o(red),
      .redirect_pc_o(rpc)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(logic [4:0] a);
      case (a)
         5'd8:    return m_badva;
         5'd12:   return m_status;
         5'd13:   return {m_bd, 15'b0, irq, 1'b0, m_code, 2'b00};
         5'd14:   return m_epc;
         default: return 32'h0;
      endcase
   endfunction

   // read one register through the port and compare with a given value
   task automatic rd(string req, logic [4:0] a, logic [31:0] exp);
      addr = a;
      #1;
      chk(req, rdata, exp);
   endtask

   // one cycle: check redirect against the model, then advance model and design
   task automatic step(string req);
      logic [7:0] en;
      logic       fault, take, rt;
      logic [4:0] code;
      int         hi;
      fault = ald | ast | ovf;
      en    = irq & m_status[15:8] & {8{m_status[0] & ~m_status[1]}};
      take  = bnd & (fault | (en != 0));
      rt    = bnd & eret & ~take;
      hi    = 0;
      for (int i = 0; i < 8; i++) if (en[i]) hi = i;
      if (ald)      code = 5'd4;
      else if (ast) code = 5'd5;
      else if (ovf) code = 5'd12;
      else          code = 5'(16 + hi);
      #2;
      chk(req, {31'b0, red}, {31'b0, take | rt});
      if (take | rt) chk(req, rpc, take ? VEC : m_epc);
      @(posedge clk);
      if (take) begin
         m_code = code;
         if (!m_status[1]) begin
            m_epc = pc; m_bd = dly; m_shadow = m_status;
         end
         m_status[4] = 1'b0;
         m_status[1] = 1'b1;
         if (ald | ast) m_badva = fa;
      end else if (rt) begin
         m_status = m_shadow;
      end else if (we) begin
         if (addr == 5'd12)      m_status = wdata & 32'h0000_FF13;
         else if (addr == 5'd14) m_epc = wdata;
      end
      @(negedge clk);
      bnd = 0; ovf = 0; ald = 0; ast = 0; eret = 0; we = 0; dly = 0;
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      we = 1; addr = a; wdata = d;
      step("R11");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      rd("R1", 5'd8, 0); rd("R1", 5'd12, 0); rd("R1", 5'd13, 0); rd("R1", 5'd14, 0);
      #1 chk("R1", {31'b0, red}, 32'h0);
      // R2: unused number reads zero
      rd("R2", 5'd5, 0); rd("R2", 5'd31, 0);
      // R3: writable status bits
      wr(5'd12, 32'hFFFF_FFFF);
      rd("R3", 5'd12, 32'h0000_FF13);
      wr(5'd12, 32'h0000_FF01);
      // R4: cause and bad address ignore writes; pending is live
      wr(5'd13, 32'hFFFF_FFFF);
      wr(5'd8, 32'h1234_5678);
      rd("R4", 5'd13, 0); rd("R4", 5'd8, 0);
      irq = 8'hA5;
      rd("R4", 5'd13, 32'h0000_A500);
      irq = 8'h00;
      // R5: fault off the boundary is dropped
      ovf = 1; step("R5");
      rd("R5", 5'd13, 0); rd("R5", 5'd12, 32'h0000_FF01);
      // R6/R11: overflow entry with a competing EPC write
      bnd = 1; ovf = 1; pc = 32'h0040_0100; dly = 1;
      we = 1; addr = 5'd14; wdata = 32'h1111;
      step("R6");
      rd("R6", 5'd14, 32'h0040_0100); rd("R6", 5'd12, 32'h0000_FF03);
      rd("R7", 5'd13, 32'h8000_0030); rd("R9", 5'd8, 0);
      // R8: exception level blocks interrupts
      irq = 8'h80; bnd = 1; step("R8");
      irq = 8'h00;
      // R12: nested store address error keeps EPC
      bnd = 1; ast = 1; pc = 32'h999; fa = 32'hDEAD_0003; step("R12");
      rd("R12", 5'd14, 32'h0040_0100); rd("R7", 5'd13, 32'h8000_0014);
      rd("R9", 5'd8, 32'hDEAD_0003);
      // R10/R11: return with a competing status write
      bnd = 1; eret = 1; we = 1; addr = 5'd12; wdata = 0; step("R10");
      rd("R10", 5'd12, 32'h0000_FF01);
      // R7: fault beats interrupt
      irq = 8'h81; bnd = 1; ald = 1; pc = 32'h500; fa = 32'h40; step("R7");
      rd("R7", 5'd13, 32'h0000_8110); rd("R9", 5'd8, 32'h40);
      bnd = 1; eret = 1; step("R10");
      rd("R10", 5'd12, 32'h0000_FF01);
      // R7: highest line wins
      bnd = 1; pc = 32'h600; step("R7");
      rd("R7", 5'd13, 32'h0000_815C); rd("R6", 5'd14, 32'h600);
      bnd = 1; eret = 1; step("R10");
      // R8: mask bit gates a line
      irq = 8'h00; wr(5'd12, 32'h0000_0101);
      irq = 8'h80; bnd = 1; step("R8");
      irq = 8'h81; bnd = 1; step("R7");
      rd("R7", 5'd13, 32'h0000_8140);
      bnd = 1; eret = 1; step("R10");
      rd("R10", 5'd12, 32'h0000_0101);
      // R8: interrupt enable off
      irq = 8'h00; wr(5'd12, 32'h0000_FF00);
      irq = 8'hFF; bnd = 1; step("R8");
      irq = 8'h00;
      // constrained random traffic against the model
      for (int k = 0; k < 400; k++) begin
         logic [2:0] pick;
         bnd   = ($urandom % 2) == 0;
         ovf   = ($urandom % 8) == 0;
         ald   = ($urandom % 10) == 0;
         ast   = ($urandom % 10) == 0;
         eret  = ($urandom % 5) == 0;
         dly   = $urandom % 2;
         irq   = 8'($urandom) & 8'($urandom);
         pc    = $urandom & 32'hFFFF_FFFC;
         fa    = $urandom;
         we    = ($urandom % 4) == 0;
         pick  = 3'($urandom % 5);
         addr  = (pick == 0) ? 5'd8 : (pick == 1) ? 5'd12 :
                 (pick == 2) ? 5'd13 : (pick == 3) ? 5'd14 : 5'd3;
         wdata = $urandom;
         step("R6");
         for (int j = 0; j < 5; j++) begin
            logic [4:0] a;
            a = (j == 0) ? 5'd8 : (j == 1) ? 5'd12 : (j == 2) ? 5'd13 :
                (j == 3) ? 5'd14 : 5'd9;
            rd("R2", a, m_read(a));
         end
      end
      finish_run();
   end
endmodule